// File: doc/BRIEF.md
# 10 Mb/s Carrier Sense, Collision and Jabber Control

This block produces the carrier sense and collision indications of a 10 Mb/s twisted-pair transceiver. It also produces the signal that disables the transmitter. It watches the transmit enable from the MAC side and the data-valid indication from the receive squelch. A duplex mode bit and two configuration bits shape what it reports.

Three sources share the collision output:
- a true collision, when transmit and receive overlap in half duplex;
- the heartbeat pulse that follows every completed transmission;
- the lockout raised by the jabber watchdog when a transmission runs too long.

Carrier sense covers both directions in half duplex and only the receive direction in full duplex. All timer lengths are parameters counted in clock cycles, so a simulation can run with short values.

Both outputs are registered, so each follows its cause by one clock edge. The transmitter-disable output comes straight from the watchdog state register.

Top module: `tp10_activity_ctrl`

## Requirements
- R1: While reset is asserted, `crs_o`, `col_o` and `tx_block_o` are all 0.
- R2: In half duplex (`full_duplex_i`=0), `crs_o` is 1 one clock edge after a cycle in which transmit enable (when not locked out) or `rx_valid_i` is 1. Otherwise it is 0.
- R3: In full duplex (`full_duplex_i`=1), `crs_o` follows `rx_valid_i` with one edge of delay, and transmit activity has no effect on it.
- R4: In half duplex, `col_o` is 1 one edge after every cycle in which transmit and receive are both active. In full duplex, this overlap never raises `col_o`.
- R5: In half duplex with `sqe_off_i`=0, take the first edge that samples `tx_en_i` low after a non-locked transmission. `col_o` rises SQE_GAP_CYC+1 edges after that edge and stays 1 for exactly SQE_LEN_CYC cycles.
- R6: No heartbeat pulse appears on `col_o` while `full_duplex_i`=1 or `sqe_off_i`=1. Setting either bit cancels a pending pulse.
- R7: If `tx_en_i` is sampled high while a heartbeat is waiting or in progress, the heartbeat is cancelled. No pulse appears while transmit enable stays high.
- R8: When `tx_en_i` has been sampled high on JAB_MAX_CYC consecutive edges, `tx_block_o` becomes 1 at the last of those edges and `col_o` becomes 1 one edge later. From then on, transmit activity no longer drives `crs_o`.
- R9: The lockout holds while `tx_en_i` stays high. It ends at the edge that samples `tx_en_i` low for the UNJAB_CYC-th consecutive time, and `col_o` falls one edge later. Any high sample of `tx_en_i` restarts this count.
- R10: While `jab_off_i`=1, the watchdog never locks out. `tx_block_o` stays 0 however long `tx_en_i` is high.
- R11: The end of a transmission that was locked out produces no heartbeat pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_en_i | input | 1 | Transmit enable from the MAC side |
| rx_valid_i | input | 1 | Receive data valid from the squelch |
| full_duplex_i | input | 1 | 1 = full duplex, 0 = half duplex |
| sqe_off_i | input | 1 | 1 = suppress the heartbeat pulse |
| jab_off_i | input | 1 | 1 = disable the jabber watchdog |
| crs_o | output | 1 | Carrier sense |
| col_o | output | 1 | Collision (true collision, heartbeat or jabber lockout) |
| tx_block_o | output | 1 | Transmitter disabled by the jabber watchdog |

## Verification
The bench drives inputs on falling edges and samples on the falling edge after the number of rising edges each result needs.
- `crs_o` and collision overlaps are checked one edge after the stimulus.
- `tx_block_o` is checked exactly at the JAB_MAX_CYC-th high sample and at the UNJAB_CYC-th low sample.
- The lockout's effect on `col_o` is checked one edge after each of those.
- The heartbeat is checked cycle by cycle in a window around SQE_GAP_CYC+2 to SQE_GAP_CYC+SQE_LEN_CYC+1 edges after the falling input. This catches both a late or short pulse and a stray one.

Each of these boundaries is checked one cycle before and at the cycle it falls due.

// File: rtl/tp10_activity_pkg.sv
package tp10_activity_pkg;

  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_PULSE = 2'd2
  } hb_state_t;

  function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

endpackage

// File: rtl/tp10_jab_guard.sv
module tp10_jab_guard #(
  parameter int unsigned JAB_MAX_CYC = 240000,
  parameter int unsigned UNJAB_CYC   = 2560000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic jab_off,
  output logic jammed_o
);
  import tp10_activity_pkg::*;

  localparam int unsigned CW = cnt_width(JAB_MAX_CYC, UNJAB_CYC);
  localparam logic [CW-1:0] JAB_LAST   = CW'(JAB_MAX_CYC - 1);
  localparam logic [CW-1:0] UNJAB_LAST = CW'(UNJAB_CYC - 1);

  logic          jam_q, jam_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    jam_d = jam_q;
    cnt_d = cnt_q;
    if (jab_off) begin
      jam_d = 1'b0;
      cnt_d = '0;
    end else if (!jam_q) begin
      if (!tx_en) begin
        cnt_d = '0;
      end else if (cnt_q == JAB_LAST) begin
        jam_d = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      if (tx_en) begin
        cnt_d = '0;
      end else if (cnt_q == UNJAB_LAST) begin
        jam_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      jam_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      jam_q <= jam_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign jammed_o = jam_q;

  assert_hold_while_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (jam_q && tx_en && !jab_off) |=> jam_q);

  assert_watchdog_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    jab_off |=> !jam_q);

  assert_no_jam_without_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!jam_q && !tx_en) |=> !jam_q);

endmodule

// File: rtl/tp10_heartbeat.sv
module tp10_heartbeat #(
  parameter int unsigned SQE_GAP_CYC = 10,
  parameter int unsigned SQE_LEN_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic jammed,
  input  logic hb_allow,
  output logic pulse_o
);
  import tp10_activity_pkg::*;

  localparam int unsigned CW = cnt_width(SQE_GAP_CYC, SQE_LEN_CYC);
  localparam logic [CW-1:0] GAP_LAST = CW'(SQE_GAP_CYC - 1);
  localparam logic [CW-1:0] LEN_LAST = CW'(SQE_LEN_CYC - 1);

  hb_state_t     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          prev_tx_q;
  logic          tx_done;
  logic          cnt_en;

  // a transmission that was not locked out has just ended
  assign tx_done = prev_tx_q && !tx_en && !jammed;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!hb_allow || tx_en) begin
      st_d  = HB_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        HB_IDLE: begin
          if (tx_done) begin
            st_d  = HB_WAIT;
            cnt_d = '0;
          end
        end
        HB_WAIT: begin
          if (cnt_q == GAP_LAST) begin
            st_d  = HB_PULSE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        HB_PULSE: begin
          if (cnt_q == LEN_LAST) begin
            st_d  = HB_IDLE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          st_d  = HB_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= HB_IDLE;
      cnt_q     <= '0;
      prev_tx_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      prev_tx_q <= tx_en && !jammed;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign pulse_o = (st_q == HB_PULSE);

  assert_quiet_when_barred_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hb_allow |=> (st_q == HB_IDLE));

  assert_cancel_on_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |=> (st_q == HB_IDLE));

  assert_pulse_not_cut_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == HB_PULSE) && (cnt_q != LEN_LAST) && hb_allow && !tx_en) |=> (st_q == HB_PULSE));

  assert_no_hb_after_jam_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == HB_IDLE) && jammed) |=> (st_q == HB_IDLE));

endmodule

// File: rtl/tp10_line_status.sv
module tp10_line_status (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic jammed,
  input  logic rx_valid,
  input  logic full_duplex,
  input  logic hb_pulse,
  output logic crs_o,
  output logic col_o
);
  logic tx_live;
  logic crs_d, col_d, crs_q, col_q;

  always_comb begin
    tx_live = tx_en && !jammed;
    crs_d   = rx_valid || (!full_duplex && tx_live);
    col_d   = (!full_duplex && tx_live && rx_valid) || hb_pulse || jammed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crs_q <= 1'b0;
      col_q <= 1'b0;
    end else begin
      crs_q <= crs_d;
      col_q <= col_d;
    end
  end

  assign crs_o = crs_q;
  assign col_o = col_q;

  assert_fd_rx_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_duplex && !rx_valid) |=> !crs_q);

  assert_overlap_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_duplex && tx_en && !jammed && rx_valid) |=> col_q);

  assert_jam_col_R8: assert property (@(posedge clk) disable iff (!rst_n)
    jammed |=> col_q);

  assert_hd_carrier_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_duplex && tx_en && !jammed) |=> crs_q);

endmodule

// File: rtl/tp10_activity_ctrl.sv
module tp10_activity_ctrl #(
  parameter int unsigned SQE_GAP_CYC = 10,
  parameter int unsigned SQE_LEN_CYC = 10,
  parameter int unsigned JAB_MAX_CYC = 240000,
  parameter int unsigned UNJAB_CYC   = 2560000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en_i,
  input  logic rx_valid_i,
  input  logic full_duplex_i,
  input  logic sqe_off_i,
  input  logic jab_off_i,
  output logic crs_o,
  output logic col_o,
  output logic tx_block_o
);
  logic rst_meta_q, rst_sync_q;
  logic jammed;
  logic hb_pulse;
  logic hb_allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign hb_allow = !full_duplex_i && !sqe_off_i;

  tp10_jab_guard #(
    .JAB_MAX_CYC(JAB_MAX_CYC),
    .UNJAB_CYC  (UNJAB_CYC)
  ) u_jab (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .tx_en   (tx_en_i),
    .jab_off (jab_off_i),
    .jammed_o(jammed)
  );

  tp10_heartbeat #(
    .SQE_GAP_CYC(SQE_GAP_CYC),
    .SQE_LEN_CYC(SQE_LEN_CYC)
  ) u_hb (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .tx_en   (tx_en_i),
    .jammed  (jammed),
    .hb_allow(hb_allow),
    .pulse_o (hb_pulse)
  );

  tp10_line_status u_stat (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .tx_en      (tx_en_i),
    .jammed     (jammed),
    .rx_valid   (rx_valid_i),
    .full_duplex(full_duplex_i),
    .hb_pulse   (hb_pulse),
    .crs_o      (crs_o),
    .col_o      (col_o)
  );

  assign tx_block_o = jammed;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_sync_q |-> (!crs_o && !col_o && !tx_block_o));

  assert_block_means_col_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    tx_block_o |=> col_o);

endmodule

// File: tb/sim_tp10_activity_ctrl.sv
module sim_tp10_activity_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int GAP   = 4;
  localparam int PLEN  = 3;
  localparam int JMAX  = 20;
  localparam int UNJ   = 12;

  // {full_duplex, tx_en, rx_valid, expected crs, expected col}
  localparam logic [4:0] VEC [8] = '{
    5'b000_0_0, 5'b010_1_0, 5'b001_1_0, 5'b011_1_1,
    5'b110_0_0, 5'b101_1_0, 5'b111_1_0, 5'b000_0_0
  };

  logic clk = 1'b0;
  logic rst_n, tx_en, rx_valid, fd, sqe_off, jab_off;
  logic crs, col, blk;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tp10_activity_ctrl #(
    .SQE_GAP_CYC(GAP), .SQE_LEN_CYC(PLEN), .JAB_MAX_CYC(JMAX), .UNJAB_CYC(UNJ)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en), .rx_valid_i(rx_valid),
    .full_duplex_i(fd), .sqe_off_i(sqe_off), .jab_off_i(jab_off),
    .crs_o(crs), .col_o(col), .tx_block_o(blk)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got=%b expected=%b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tx_en = 0; rx_valid = 0; fd = 0; sqe_off = 0; jab_off = 0;
    @(negedge clk);
    tx_en = 1; rx_valid = 1;
    step(3);
    chk(crs, 1'b0, "R1", "crs in reset");
    chk(col, 1'b0, "R1", "col in reset");
    chk(blk, 1'b0, "R1", "tx_block in reset");
    tx_en = 0; rx_valid = 0;
    rst_n = 1'b1;
    step(4);

    // vector table: carrier and collision rules, heartbeat off
    sqe_off = 1;
    foreach (VEC[i]) begin
      {fd, tx_en, rx_valid} = VEC[i][4:2];
      step(1);
      chk(crs, VEC[i][1], VEC[i][4] ? "R3" : "R2", $sformatf("crs vec %0d", i));
      chk(col, VEC[i][0], "R4", $sformatf("col vec %0d", i));
    end
    {fd, tx_en, rx_valid} = 3'b000;
    step(2);

    // R5: heartbeat timing in half duplex
    sqe_off = 0;
    tx_en = 1; step(2);
    tx_en = 0;
    for (int k = 1; k <= GAP + PLEN + 4; k++) begin
      step(1);
      chk(col, (k >= GAP + 2 && k <= GAP + PLEN + 1), "R5", $sformatf("hb col k=%0d", k));
    end

    // R6: suppressed in full duplex, then with sqe_off
    fd = 1;
    tx_en = 1; step(2);
    tx_en = 0;
    for (int k = 1; k <= GAP + PLEN + 3; k++) begin
      step(1);
      chk(col, 1'b0, "R6", $sformatf("fd no hb k=%0d", k));
    end
    fd = 0; sqe_off = 1;
    tx_en = 1; step(2);
    tx_en = 0;
    for (int k = 1; k <= GAP + PLEN + 3; k++) begin
      step(1);
      chk(col, 1'b0, "R6", $sformatf("sqe_off no hb k=%0d", k));
    end
    sqe_off = 0;

    // R7: new transmission during the wait cancels the heartbeat
    tx_en = 1; step(2);
    tx_en = 0; step(3);
    tx_en = 1;
    for (int k = 1; k <= GAP + PLEN + 2; k++) begin
      step(1);
      chk(col, 1'b0, "R7", $sformatf("cancelled hb k=%0d", k));
    end
    sqe_off = 1; tx_en = 0; step(3); sqe_off = 0;

    // R8: jabber lockout
    tx_en = 1;
    step(JMAX - 1);
    chk(blk, 1'b0, "R8", "tx_block one before limit");
    chk(col, 1'b0, "R8", "col before limit");
    step(1);
    chk(blk, 1'b1, "R8", "tx_block at limit");
    step(1);
    chk(col, 1'b1, "R8", "col after lockout");
    chk(crs, 1'b0, "R8", "crs drops when locked out");
    step(5);
    chk(blk, 1'b1, "R9", "lockout held while tx high");

    // R9: unjab restart, then release
    tx_en = 0; step(5);
    tx_en = 1; step(1);
    tx_en = 0;
    step(UNJ - 1);
    chk(blk, 1'b1, "R9", "tx_block one before unjab end");
    chk(col, 1'b1, "R9", "col one before unjab end");
    step(1);
    chk(blk, 1'b0, "R9", "tx_block released");
    step(1);
    chk(col, 1'b0, "R9", "col released");
    for (int k = 1; k <= GAP + PLEN + 3; k++) begin
      step(1);
      chk(col, 1'b0, "R11", $sformatf("no hb after jab k=%0d", k));
    end

    // R10: watchdog disabled
    jab_off = 1; sqe_off = 1;
    tx_en = 1;
    step(JMAX + 5);
    chk(blk, 1'b0, "R10", "no lockout with jab_off");
    chk(crs, 1'b1, "R10", "crs still from tx");
    chk(col, 1'b0, "R10", "no col with jab_off");
    tx_en = 0; step(3);

    finish_run();
  end
endmodule